// File: doc/BRIEF.md
# Seconds Real-Time Counter Peripheral

This peripheral keeps a 32-bit count of elapsed seconds. It divides the system clock by a fixed, parameterised number of cycles. Each time that division completes, the seconds count advances by one. Software uses a 4 KB register space to read the running count, to preset it through a load register, and to program a match value. An interrupt flag is raised when the count arrives at the match value. The flag has a mask, a masked view and a write-any-value clear register. The flag combined with the mask drives a single registered interrupt pin. The top eight words of the space form a read-only identification window, with one byte in each word.

The bus is a plain single-cycle register port. A write takes effect at the clock edge where `wr_en_i` is high. Read data is a combinational function of `addr_i` and current state, so every access completes in the cycle it is presented. The port has no valid/ready handshake and applies no back-pressure, because every register can always accept or supply data. Address bits [1:0] are ignored, and decode uses word offsets.

Top module: `rtc_seconds_top`

## Requirements
- R1: After reset the seconds count, match value, load value, interrupt mask, raw flag and `irq_o` are all 0.
- R2: The seconds count, read at offset 0x00, increases by one every `CYCLES_PER_SEC` system clock cycles.
- R3: A write to offset 0x08 sets the seconds count to the written value at that edge and restarts the prescaler, so the next increment comes `CYCLES_PER_SEC` cycles after the write. Offset 0x08 reads back the last value written.
- R4: Offset 0x04 holds the match value and reads back the last value written.
- R5: The raw flag (offset 0x14, bit 0) is set when an increment makes the count equal to the match value. It then stays set until cleared. A load that writes the match value directly does not set it.
- R6: A write of any data to offset 0x1C clears the raw flag.
- R7: A write to offset 0x10 keeps only data bit 0 as the mask. Reads of 0x10 return that bit in bit 0 and zero in all other bits.
- R8: Offset 0x18 reads raw flag AND mask in bit 0. `irq_o` is a register output that always equals that value.
- R9: Offset 0x0C always reads 1. Writes to it have no effect, and the count keeps advancing.
- R10: Word offsets 0xFE0 to 0xFFC read, in ascending address order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Each byte sits in bits [7:0] and the upper bits are zero.
- R11: Reads of undefined offsets, including the write-only 0x1C, return 0. Writes to undefined offsets or to the identification window change no register.
- R12: The count wraps from 0xFFFFFFFF to 0 on the next increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte address within the 4 KB space |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered masked interrupt |

## Verification
The assertions assume `wr_en_i` is never unknown after reset and that each write lasts exactly one cycle. The bench meets this by driving the strobe only on falling edges, for one full period. The increment and wrap properties assume the count is changed only by a tick or a load. The bench never writes a load value in the same cycle that a tick is due, so a load is only ever checked against its own write. The property that the raw flag stays set relies on the clear register being the only path that lowers it. The bench issues clears only at known times, never in a cycle where a match increment lands.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = ADDR_W - 2;

  // word offsets (byte offset >> 2)
  localparam logic [WORD_W-1:0] W_COUNT = 10'h000;
  localparam logic [WORD_W-1:0] W_MATCH = 10'h001;
  localparam logic [WORD_W-1:0] W_LOAD  = 10'h002;
  localparam logic [WORD_W-1:0] W_CTRL  = 10'h003;
  localparam logic [WORD_W-1:0] W_MASK  = 10'h004;
  localparam logic [WORD_W-1:0] W_RAW   = 10'h005;
  localparam logic [WORD_W-1:0] W_MIS   = 10'h006;
  localparam logic [WORD_W-1:0] W_CLR   = 10'h007;
  // identification window: top eight words, selected by word bits [9:3]
  localparam logic [WORD_W-4:0] ID_PAGE = 7'h7F;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned CYCLES_PER_TICK = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CYCLES_PER_TICK > 1) ? $clog2(CYCLES_PER_TICK) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_TICK - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (restart_i || cnt_q == LAST) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] match_val_i,
  output logic [DATA_W-1:0] count_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] count_inc;

  assign count_inc = count_q + 1'b1;
  assign count_o   = count_q;
  assign hit_o     = tick_i && !load_i && (count_inc == match_val_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (tick_i) count_q <= count_inc;
  end

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i) |=> (count_q == $past(count_q) + 1'b1));
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q == $past(load_val_i)));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(count_q));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  input  logic mask_we_i,
  input  logic mask_bit_i,
  output logic raw_o,
  output logic mask_o,
  output logic irq_o
);
  logic raw_q, raw_d;
  logic mask_q, mask_d;
  logic irq_q;

  always_comb begin
    raw_d = raw_q;
    if (clr_i) raw_d = 1'b0;
    if (hit_i) raw_d = 1'b1;
    mask_d = mask_we_i ? mask_bit_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= raw_d & mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  assert_raw_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr_i) |=> raw_q);
  assert_raw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> raw_q);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_i) |=> !raw_q);
  assert_irq_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (raw_q & mask_q));
endmodule

// File: rtl/rtc_seconds_top.sv
module rtc_seconds_top
  import rtc_pkg::*;
#(
  parameter int unsigned CYCLES_PER_SEC = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] word;
  logic              unused_addr_bits;
  logic              we_match, we_load, we_mask, we_clr;
  logic [DATA_W-1:0] match_q, load_q, count;
  logic              tick, hit, raw, mask;

  assign word             = addr_i[ADDR_W-1:2];
  assign unused_addr_bits = ^addr_i[1:0];

  assign we_match = wr_en_i && (word == W_MATCH);
  assign we_load  = wr_en_i && (word == W_LOAD);
  assign we_mask  = wr_en_i && (word == W_MASK);
  assign we_clr   = wr_en_i && (word == W_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      load_q  <= '0;
    end else begin
      if (we_match) match_q <= wdata_i;
      if (we_load)  load_q  <= wdata_i;
    end
  end

  rtc_prescaler #(.CYCLES_PER_TICK(CYCLES_PER_SEC)) prescaler_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (we_load),
    .tick_o    (tick)
  );

  rtc_seconds seconds_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .load_i      (we_load),
    .load_val_i  (wdata_i),
    .match_val_i (match_q),
    .count_o     (count),
    .hit_o       (hit)
  );

  rtc_irq_ctrl irq_ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .clr_i      (we_clr),
    .mask_we_i  (we_mask),
    .mask_bit_i (wdata_i[0]),
    .raw_o      (raw),
    .mask_o     (mask),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (word[WORD_W-1:3] == ID_PAGE) begin
      rdata_o[7:0] = id_byte(word[2:0]);
    end else begin
      case (word)
        W_COUNT: rdata_o = count;
        W_MATCH: rdata_o = match_q;
        W_LOAD:  rdata_o = load_q;
        W_CTRL:  rdata_o[0] = 1'b1;
        W_MASK:  rdata_o[0] = mask;
        W_RAW:   rdata_o[0] = raw;
        W_MIS:   rdata_o[0] = raw & mask;
        default: rdata_o = '0;
      endcase
    end
  end

  assert_match_guarded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we_match |=> $stable(match_q));
  assert_load_guarded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we_load |=> $stable(load_q));
  assert_no_load_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_load |-> !hit);
endmodule

// File: tb/rtc_seconds_top_tb_top.sv
`timescale 1ns/1ps
module rtc_seconds_top_tb_top;
  localparam int unsigned DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wen = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_seconds_top #(.CYCLES_PER_SEC(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wen),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] exp_id(input int i);
    case (i)
      0: exp_id = 8'h31; 1: exp_id = 8'h10; 2: exp_id = 8'h14; 3: exp_id = 8'h00;
      4: exp_id = 8'h0D; 5: exp_id = 8'hF0; 6: exp_id = 8'h05; default: exp_id = 8'hB1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    logic [31:0] base;
    cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd("R1 count", 12'h000, 32'd0);
    chk_rd("R1 match", 12'h004, 32'd0);
    chk_rd("R1 load", 12'h008, 32'd0);
    chk_rd("R1 mask", 12'h010, 32'd0);
    chk_rd("R1 raw", 12'h014, 32'd0);
    chk_rd("R1 masked", 12'h018, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 / R3 sweep over load values and second boundaries
    for (int s = 0; s < 4; s++) begin
      base = (s == 0) ? 32'd1 : (s == 1) ? 32'h0000_1234 : (s == 2) ? 32'h7FFF_FFF0 : 32'hC0DE_0000;
      wr(12'h008, base);
      chk_rd("R3 count after load", 12'h000, base);
      chk_rd("R3 load readback", 12'h008, base);
      for (int k = 1; k <= 3; k++) begin
        cyc(DIV - 1);
        chk_rd("R2 before tick", 12'h000, base + k - 1);
        cyc(1);
        chk_rd("R2 after tick", 12'h000, base + k);
      end
    end
    // R3 restart: reload mid-second, next increment DIV cycles later
    wr(12'h008, 32'd40);
    cyc(DIV / 2);
    wr(12'h008, 32'd50);
    cyc(DIV - 1);
    chk_rd("R3 restart hold", 12'h000, 32'd50);
    cyc(1);
    chk_rd("R3 restart step", 12'h000, 32'd51);

    // R12 wrap (match is 0, so the flag also rises: R5)
    wr(12'h008, 32'hFFFF_FFFF);
    cyc(DIV);
    chk_rd("R12 wrap", 12'h000, 32'd0);
    chk_rd("R5 hit at wrap", 12'h014, 32'd1);
    wr(12'h01C, 32'd0);
    chk_rd("R6 clear", 12'h014, 32'd0);

    // R4 match register
    wr(12'h004, 32'hA5A5_0001);
    chk_rd("R4 match readback", 12'h004, 32'hA5A5_0001);

    // R7 mask keeps bit 0
    wr(12'h010, 32'hFFFF_FFFE);
    chk_rd("R7 mask even", 12'h010, 32'd0);
    wr(12'h010, 32'h0000_0003);
    chk_rd("R7 mask odd", 12'h010, 32'd1);
    chk("R8 irq idle masked-in", {31'd0, irq}, 32'd0);
    wr(12'h010, 32'd0);

    // R5 / R8 match event
    wr(12'h004, 32'd102);
    wr(12'h008, 32'd100);
    chk_rd("R5 no flag after load", 12'h014, 32'd0);
    cyc(2 * DIV - 1);
    chk_rd("R5 flag not yet", 12'h014, 32'd0);
    cyc(1);
    chk_rd("R5 flag set", 12'h014, 32'd1);
    chk_rd("R8 masked with mask 0", 12'h018, 32'd0);
    chk("R8 irq with mask 0", {31'd0, irq}, 32'd0);
    wr(12'h010, 32'd1);
    chk_rd("R8 masked with mask 1", 12'h018, 32'd1);
    chk("R8 irq with mask 1", {31'd0, irq}, 32'd1);
    cyc(2 * DIV);
    chk_rd("R5 flag sticky", 12'h014, 32'd1);
    wr(12'h01C, 32'h55);
    chk_rd("R6 flag cleared", 12'h014, 32'd0);
    chk_rd("R6 masked cleared", 12'h018, 32'd0);
    chk("R6 irq cleared", {31'd0, irq}, 32'd0);
    // R5 load straight to match value does not set flag
    wr(12'h008, 32'd102);
    cyc(DIV + 1);
    chk_rd("R5 load equal no flag", 12'h014, 32'd0);
    chk("R5 load equal irq", {31'd0, irq}, 32'd0);

    // R9 control
    wr(12'h00C, 32'd0);
    chk_rd("R9 ctrl reads 1", 12'h00C, 32'd1);
    wr(12'h008, 32'd500);
    wr(12'h00C, 32'd0);
    cyc(DIV - 1);
    chk_rd("R9 still counting", 12'h000, 32'd501);

    // R10 identification window
    for (int i = 0; i < 8; i++)
      chk_rd("R10 id byte", 12'hFE0 + 12'(4 * i), {24'd0, exp_id(i)});

    // R11 ignored writes
    wr(12'h004, 32'h1111_2222);
    wr(12'h008, 32'h3333_4444);
    wr(12'h010, 32'd1);
    wr(12'hFE0, 32'hFFFF_FFFF);
    wr(12'hFFC, 32'd0);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h800, 32'd0);
    chk_rd("R11 match untouched", 12'h004, 32'h1111_2222);
    chk_rd("R11 load untouched", 12'h008, 32'h3333_4444);
    chk_rd("R11 mask untouched", 12'h010, 32'd1);
    chk_rd("R11 id untouched", 12'hFE0, 32'h31);
    chk_rd("R11 id last untouched", 12'hFFC, 32'hB1);
    chk_rd("R11 clear reads 0", 12'h01C, 32'd0);
    for (int a = 12'h020; a < 12'hFE0; a += 4)
      chk_rd("R11 undefined reads 0", 12'(a), 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule